// File: doc/BRIEF.md
# Burst-Mode Synchronous Serial Port

This block connects a processor-side register interface to a four-wire synchronous serial link. Words written by the processor go into a four-entry transmit queue. Each word is sent in its own burst frame. The port raises its own frame-sync pulse, shifts the word out MSB first on an externally supplied bit clock, and releases the data line once the word is complete. The receive side follows an incoming frame-sync pulse, shifts sixteen bits in MSB first, and places each finished word in a four-entry receive queue. The processor reads that queue through a show-ahead data port.

The external bit clock is sampled in the processor clock domain. Each high and low phase of that clock must last at least two processor clock cycles. Serial edges take effect at the first processor clock edge that sees the new level. The port raises single-cycle interrupt pulses when a word leaves the transmit queue, when the transmitter runs dry, and when a received word is stored. It keeps sticky overrun flags for writes that are refused and for received words that are lost. A synchronous clear input returns the whole port to its idle state.

Top module: `ssp_burst_port`

## Requirements
- R1: Both queues hold four words each and keep first-in, first-out order. `rdData` always shows the oldest received word. A processor write pushes `wrData` into the transmit queue, and `rdEn` pops the receive queue.
- R2: After a word is written to an idle transmitter, `txFs` goes high at the next serial rising edge. It stays high for exactly one bit period.
- R3: At the serial falling edge that follows, the oldest queued word moves into the transmit shift register. At the same time `txIrq` pulses high for one processor cycle, while `txFs` is still high and `txOe` is still low.
- R4: At the rising edge that ends the frame sync, `txOe` goes high and `txData` carries bit 15. The remaining bits follow on the next fifteen rising edges, in descending order. At the seventeenth rising edge `txOe` goes low.
- R5: If the transmit queue still holds a word at that seventeenth rising edge, `txFs` is raised at that same edge and the next word follows. Otherwise `txIrq` pulses once more and the transmitter goes idle. Each word therefore produces one `txIrq` pulse, and each run of back-to-back words produces one extra pulse at its end.
- R6: The receiver arms on a serial falling edge that sees `rxFs` high, and it stays armed for as long as `rxFs` stays high. The first falling edge that sees `rxFs` low samples bit 15 from `rxData`. The sixteenth sampling edge stores the word in the receive queue and pulses `rxIrq` for one cycle.
- R7: A write while the transmit queue holds four words is ignored, and it sets `txOverrun`, which stays set until clear.
- R8: A word that completes while the receive queue holds four words is discarded. In that case `rxIrq` does not pulse and `rxOverrun` is set and stays set. The queue's earlier contents are kept.
- R9: `rdEn` while the receive queue is empty has no effect on later reads.
- R10: After reset, and one cycle after `portClear`, both queues are empty and both shift sequences are idle. In that state `txFs` and `txOe` are low and both overrun flags are clear.
- R11: `txReady` is high exactly when the transmit queue has room. `rxReady` is high exactly when the receive queue holds a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portClear | input | 1 | Synchronous clear of queues, shift logic and flags |
| wrEn | input | 1 | Push wrData into the transmit queue |
| wrData | input | 16 | Word to transmit |
| rdEn | input | 1 | Pop the receive queue |
| rdData | output | 16 | Oldest received word |
| txReady | output | 1 | Transmit queue has room |
| rxReady | output | 1 | Receive queue holds a word |
| txIrq | output | 1 | Transmit interrupt pulse |
| rxIrq | output | 1 | Receive interrupt pulse |
| txOverrun | output | 1 | Sticky: a write was refused |
| rxOverrun | output | 1 | Sticky: a received word was lost |
| serClk | input | 1 | External serial bit clock |
| txFs | output | 1 | Transmit frame-sync pulse |
| txData | output | 1 | Serial transmit data, zero while released |
| txOe | output | 1 | Drive enable for the transmit data line |
| rxFs | input | 1 | Receive frame-sync pulse |
| rxData | input | 1 | Serial receive data |

## Verification
Two cases can fall in the same cycle: a processor write can land on the transmit queue in the cycle that pops it into the shift register, and a processor read can hit the receive queue in the cycle that a finished word is pushed. The bench sweeps the second write of a pair across sixteen consecutive cycle offsets after the first, so that the write passes over the pop cycle. It also sweeps a single read across sixteen offsets around the computed arrival of the second looped-back word. Each sweep point is judged by reading both words back and comparing them, in order, with the words written, and by checking that the receive queue is empty afterwards.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SYNC,
    TX_LOADED,
    TX_SHIFT
  } txState_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ARMED,
    RX_SHIFT
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txPop;
    logic txShift;
    logic rxShift;
    logic rxPush;
    logic clear;
  } sspStrobes_t;

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int  PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int  CW   = $clog2(DEPTH + 1);
  localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0) && (DEPTH > 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr, wrNext, rdNext;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign doPush   = push & ~full & ~clear;
  assign doPop    = pop & ~empty & ~clear;
  assign headData = mem[rdPtr];

  generate
    if (POW2) begin : gen_wrap_natural
      assign wrNext = wrPtr + PW'(1);
      assign rdNext = rdPtr + PW'(1);
    end else begin : gen_wrap_compare
      assign wrNext = (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + PW'(1);
      assign rdNext = (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + PW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrNext;
      if (doPop)  rdPtr <= rdNext;
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobes_t       strb,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  input  logic              serIn,
  output logic              txBit,
  output logic              txEmpty,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              rxFull
);
  logic [WORD_W-1:0] txHead;
  logic [WORD_W-1:0] xmitShift;
  logic [WORD_W-1:0] recvShift;
  logic [WORD_W-1:0] recvWord;

  assign recvWord = {recvShift[WORD_W-2:0], serIn};
  assign txBit    = xmitShift[WORD_W-1];

  ssp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txQueue (
    .clk(clk), .rstN(rstN), .clear(strb.clear),
    .push(wrEn), .pushData(wrData),
    .pop(strb.txPop), .headData(txHead),
    .empty(txEmpty), .full(txFull)
  );

  ssp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxQueue (
    .clk(clk), .rstN(rstN), .clear(strb.clear),
    .push(strb.rxPush), .pushData(recvWord),
    .pop(rdEn), .headData(rdData),
    .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xmitShift <= '0;
      recvShift <= '0;
    end else if (strb.clear) begin
      xmitShift <= '0;
      recvShift <= '0;
    end else begin
      if (strb.txPop)        xmitShift <= txHead;
      else if (strb.txShift) xmitShift <= {xmitShift[WORD_W-2:0], 1'b0};
      if (strb.rxShift)      recvShift <= recvWord;
    end
  end
endmodule

// File: rtl/ssp_control.sv
module ssp_control
  import ssp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        portClear,
  input  logic        serClk,
  input  logic        rxFs,
  input  logic        wrEn,
  input  logic        txEmpty,
  input  logic        txFull,
  input  logic        rxFull,
  output sspStrobes_t strb,
  output logic        txFs,
  output logic        txOe,
  output logic        txIrq,
  output logic        rxIrq,
  output logic        txOverrun,
  output logic        rxOverrun
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(WORD_W - 1);

  txState_t         txState;
  rxState_t         rxState;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic             serClkQ, serRise, serFall;

  assign serRise = serClk & ~serClkQ;
  assign serFall = ~serClk & serClkQ;

  always_comb begin
    strb       = '0;
    strb.clear = portClear;
    if (!portClear) begin
      strb.txPop   = (txState == TX_SYNC) && serFall;
      strb.txShift = (txState == TX_SHIFT) && serRise && (txCnt != TX_LAST);
      strb.rxShift = serFall && (((rxState == RX_ARMED) && !rxFs) ||
                                 (rxState == RX_SHIFT));
      strb.rxPush  = serFall && (rxState == RX_SHIFT) && (rxCnt == RX_LAST);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serClkQ <= 1'b0;
    else       serClkQ <= serClk;
  end

  // transmit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
      txFs    <= 1'b0;
      txOe    <= 1'b0;
      txIrq   <= 1'b0;
    end else if (portClear) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
      txFs    <= 1'b0;
      txOe    <= 1'b0;
      txIrq   <= 1'b0;
    end else begin
      txIrq <= 1'b0;
      case (txState)
        TX_IDLE: if (serRise && !txEmpty) begin
          txFs    <= 1'b1;
          txState <= TX_SYNC;
        end
        TX_SYNC: if (serFall) begin
          txIrq   <= 1'b1;
          txState <= TX_LOADED;
        end
        TX_LOADED: if (serRise) begin
          txFs    <= 1'b0;
          txOe    <= 1'b1;
          txCnt   <= CNT_W'(1);
          txState <= TX_SHIFT;
        end
        TX_SHIFT: if (serRise) begin
          if (txCnt == TX_LAST) begin
            txOe <= 1'b0;
            if (!txEmpty) begin
              txFs    <= 1'b1;
              txState <= TX_SYNC;
            end else begin
              txIrq   <= 1'b1;
              txState <= TX_IDLE;
            end
          end else begin
            txCnt <= txCnt + CNT_W'(1);
          end
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  // receive sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIrq   <= 1'b0;
    end else if (portClear) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIrq   <= 1'b0;
    end else begin
      rxIrq <= strb.rxPush & ~rxFull;
      if (serFall) begin
        case (rxState)
          RX_IDLE:  if (rxFs) rxState <= RX_ARMED;
          RX_ARMED: if (!rxFs) begin
            rxCnt   <= CNT_W'(1);
            rxState <= RX_SHIFT;
          end
          RX_SHIFT: begin
            if (rxCnt == RX_LAST) rxState <= RX_IDLE;
            else                  rxCnt   <= rxCnt + CNT_W'(1);
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  // sticky error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverrun <= 1'b0;
      rxOverrun <= 1'b0;
    end else if (portClear) begin
      txOverrun <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      if (wrEn && txFull)        txOverrun <= 1'b1;
      if (strb.rxPush && rxFull) rxOverrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ssp_burst_port.sv
module ssp_burst_port
  import ssp_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portClear,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              txReady,
  output logic              rxReady,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              txOverrun,
  output logic              rxOverrun,
  input  logic              serClk,
  output logic              txFs,
  output logic              txData,
  output logic              txOe,
  input  logic              rxFs,
  input  logic              rxData
);
  sspStrobes_t strb;
  logic        txBit, txEmpty, txFull, rxEmpty, rxFull;

  ssp_control #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .portClear(portClear),
    .serClk(serClk), .rxFs(rxFs), .wrEn(wrEn),
    .txEmpty(txEmpty), .txFull(txFull), .rxFull(rxFull),
    .strb(strb), .txFs(txFs), .txOe(txOe),
    .txIrq(txIrq), .rxIrq(rxIrq),
    .txOverrun(txOverrun), .rxOverrun(rxOverrun)
  );

  ssp_datapath #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .serIn(rxData), .txBit(txBit),
    .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull)
  );

  assign txReady = ~txFull;
  assign rxReady = ~rxEmpty;
  assign txData  = txBit & txOe;
endmodule

// File: rtl/ssp_burst_port_chk.sv
module ssp_burst_port_chk (
  input logic clk,
  input logic rstN,
  input logic portClear,
  input logic wrEn,
  input logic txReady,
  input logic rxReady,
  input logic rxIrq,
  input logic txOverrun,
  input logic rxOverrun,
  input logic txFs,
  input logic txOe
);
  assert_sync_data_apart_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(txFs && txOe));

  assert_msb_after_sync_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOe) |-> $past(txFs));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOverrun) |-> $past(wrEn && !txReady));

  assert_rx_irq_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxReady);

  assert_ready_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> $past(wrEn));

  assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    portClear |=> (!txFs && !txOe && txReady && !rxReady && !txOverrun && !rxOverrun));
endmodule

bind ssp_burst_port ssp_burst_port_chk u_chk (
  .clk(clk), .rstN(rstN), .portClear(portClear), .wrEn(wrEn),
  .txReady(txReady), .rxReady(rxReady), .rxIrq(rxIrq),
  .txOverrun(txOverrun), .rxOverrun(rxOverrun),
  .txFs(txFs), .txOe(txOe)
);

// File: tb/sim_ssp_burst_port.sv
module sim_ssp_burst_port;
  logic        clk, rstN, portClear, wrEn, rdEn, serClk;
  logic [15:0] wrData, rdData;
  logic        txReady, rxReady, txIrq, rxIrq, txOverrun, rxOverrun;
  logic        txFs, txData, txOe, rxFs, rxData;
  logic        loopEn, extFs, extData, monHold;

  int tests = 0, fails = 0;
  int txIrqCnt = 0, rxIrqCnt = 0;
  logic [15:0] monWords [64];
  int monCnt = 0;

  assign rxFs   = loopEn ? txFs   : extFs;
  assign rxData = loopEn ? txData : extData;

  ssp_burst_port u0 (
    .clk(clk), .rstN(rstN), .portClear(portClear),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .txReady(txReady), .rxReady(rxReady), .txIrq(txIrq), .rxIrq(rxIrq),
    .txOverrun(txOverrun), .rxOverrun(rxOverrun),
    .serClk(serClk), .txFs(txFs), .txData(txData), .txOe(txOe),
    .rxFs(rxFs), .rxData(rxData)
  );

  initial begin clk = 0; forever #10 clk = ~clk; end
  // bit period = 8 clk cycles, edges placed 5 ns from clk edges
  initial begin serClk = 0; #85; forever #80 serClk = ~serClk; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (txIrq) txIrqCnt++;
      if (rxIrq) rxIrqCnt++;
    end
  end

  // frame monitor on the transmit pins
  initial begin
    logic [15:0] w;
    int  idx;
    bit  pend, expOff;
    w = '0; idx = 0; pend = 0; expOff = 0;
    forever begin
      @(negedge serClk);
      if (monHold) begin
        pend = 0; expOff = 0; idx = 0;
      end else begin
        if (expOff) begin
          chk("R4 line released after word", {31'd0, txOe}, 0);
          expOff = 0;
        end
        if (txFs) begin
          if (pend && idx == 0) chk("R2 sync longer than one bit", 1, 0);
          pend = 1; idx = 0;
        end else if (pend) begin
          chk("R4 enable during word", {31'd0, txOe}, 1);
          w = {w[14:0], txData};
          idx++;
          if (idx == 16) begin
            monWords[monCnt % 64] = w;
            monCnt++;
            pend = 0; expOff = 1;
          end
        end
      end
    end
  end

  initial begin
    #3_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic cpuWrite(input logic [15:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic cpuRead(output logic [15:0] d);
    @(negedge clk); d = rdData; rdEn = 1;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendExt(input logic [15:0] w, input int fsLen);
    @(posedge serClk); #1 extFs = 1;
    repeat (fsLen - 1) @(posedge serClk);
    for (int i = 15; i >= 0; i--) begin
      @(posedge serClk); #1 extFs = 0; extData = w[i];
    end
    @(posedge serClk); #1 extData = 0;
  endtask

  function automatic logic [15:0] pattern(input int i);
    case (i)
      0: pattern = 16'h0000;
      1: pattern = 16'hFFFF;
      2: pattern = 16'hA5C3;
      3: pattern = 16'h8001;
      default: pattern = 16'h0001 << (i - 4);
    endcase
  endfunction

  initial begin
    logic [15:0] got;
    int t0, n, ti, ri;
    rstN = 0; portClear = 0; wrEn = 0; rdEn = 0; wrData = '0;
    loopEn = 1; extFs = 0; extData = 0; monHold = 0;
    idle(3);
    rstN = 1;
    @(negedge clk);
    chk("R10 reset txFs", {31'd0, txFs}, 0);
    chk("R10 reset txOe", {31'd0, txOe}, 0);
    chk("R11 reset txReady", {31'd0, txReady}, 1);
    chk("R11 reset rxReady", {31'd0, rxReady}, 0);
    chk("R10 reset overruns", {30'd0, txOverrun, rxOverrun}, 0);
    chk("R10 reset irqs", {30'd0, txIrq, rxIrq}, 0);

    // sync latency and load pulse on the first word
    cpuWrite(16'h3C5A);
    n = 0;
    while (!txFs && n < 40) begin @(negedge clk); n++; end
    chk("R2 sync within one bit period", {31'd0, n <= 9}, 1);
    n = 0;
    while (!txIrq && n < 40) begin @(negedge clk); n++; end
    chk("R3 load pulse while sync high", {30'd0, txFs, txOe}, 2'b10);
    @(negedge clk);
    chk("R3 load pulse one cycle", {31'd0, txIrq}, 0);
    idle(200);
    cpuRead(got);
    chk("R1 first word loopback", got, 16'h3C5A);

    // single-word sweep over patterns
    for (int i = 0; i < 20; i++) begin
      ti = txIrqCnt; ri = rxIrqCnt;
      cpuWrite(pattern(i));
      idle(200);
      chk("R4 serial bit order", monWords[(monCnt - 1) % 64], pattern(i));
      chk("R5 two tx pulses per lone word", txIrqCnt - ti, 2);
      chk("R6 one rx pulse per word", rxIrqCnt - ri, 1);
      chk("R11 rxReady after word", {31'd0, rxReady}, 1);
      cpuRead(got);
      chk("R6 received word", got, pattern(i));
      chk("R11 rxReady after pop", {31'd0, rxReady}, 0);
    end

    // fill transmit queue, fifth write refused
    ti = txIrqCnt; ri = rxIrqCnt; t0 = monCnt;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      wrEn = 1; wrData = 16'h1000 + 16'(i);
      @(negedge clk);
      if (i == 3) chk("R11 txReady low with four queued", {31'd0, txReady}, 0);
    end
    wrEn = 0;
    chk("R7 overrun flag", {31'd0, txOverrun}, 1);
    idle(700);
    chk("R5 burst tx pulses", txIrqCnt - ti, 5);
    chk("R6 burst rx pulses", rxIrqCnt - ri, 4);
    chk("R5 burst frame count", monCnt - t0, 4);
    chk("R8 no rx overrun at exactly four", {31'd0, rxOverrun}, 0);

    // receive queue full: next word dropped
    ri = rxIrqCnt;
    cpuWrite(16'hDEAD);
    idle(200);
    chk("R8 rx overrun flag", {31'd0, rxOverrun}, 1);
    chk("R8 no pulse for dropped word", rxIrqCnt - ri, 0);
    for (int i = 0; i < 4; i++) begin
      cpuRead(got);
      chk("R1 burst order kept", got, 16'h1000 + 16'(i));
    end
    chk("R7 refused word absent", {31'd0, rxReady}, 0);

    // read of empty queue
    cpuRead(got);
    cpuWrite(16'h5AA5);
    idle(200);
    cpuRead(got);
    chk("R9 empty read ignored", got, 16'h5AA5);
    chk("R9 queue empty after", {31'd0, rxReady}, 0);

    // external frames, sync held for one and three falls
    loopEn = 0;
    for (int f = 1; f <= 3; f += 2) begin
      ri = rxIrqCnt;
      sendExt(16'hC0DE ^ 16'(f), f);
      idle(20);
      chk("R6 external frame pulse", rxIrqCnt - ri, 1);
      cpuRead(got);
      chk("R6 external frame word", got, 16'hC0DE ^ 16'(f));
    end
    loopEn = 1;

    // sweep second write across the transmit pop cycle
    for (int d = 0; d < 16; d++) begin
      cpuWrite(16'h2200 + 16'(d));
      idle(d);
      cpuWrite(16'h4400 + 16'(d));
      idle(380);
      cpuRead(got);
      chk("R1 write-pop collision first", got, 16'h2200 + 16'(d));
      cpuRead(got);
      chk("R1 write-pop collision second", got, 16'h4400 + 16'(d));
      chk("R1 write-pop collision drained", {31'd0, rxReady}, 0);
    end

    // sweep a read across the receive push cycle
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      wrEn = 1; wrData = 16'h6600 + 16'(k);
      @(negedge clk);
      wrData = 16'h9900 + 16'(k);
      @(negedge clk);
      wrEn = 0;
      while (!rxReady) @(negedge clk);
      idle(128 + k);
      cpuRead(got);
      chk("R1 read-push collision first", got, 16'h6600 + 16'(k));
      idle(200);
      cpuRead(got);
      chk("R1 read-push collision second", got, 16'h9900 + 16'(k));
      chk("R1 read-push collision drained", {31'd0, rxReady}, 0);
    end

    // clear in the middle of a burst
    monHold = 1;
    cpuWrite(16'h0F0F); cpuWrite(16'hF0F0); cpuWrite(16'h1234);
    idle(60);
    @(negedge clk); portClear = 1;
    @(negedge clk); portClear = 0;
    chk("R10 clear drops sync and enable", {30'd0, txFs, txOe}, 0);
    chk("R10 clear empties tx queue", {31'd0, txReady}, 1);
    chk("R10 clear empties rx queue", {31'd0, rxReady}, 0);
    idle(400);
    chk("R10 nothing sent after clear", {30'd0, rxReady, txOe}, 0);
    monHold = 0;
    cpuWrite(16'h7E81);
    idle(200);
    cpuRead(got);
    chk("R10 port usable after clear", got, 16'h7E81);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule